// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This master-side block frees a two-wire bus that a slave has left in an unknown state after an aborted transfer, a brownout or a system reset. A single-cycle pulse on the trigger input starts a fixed pattern on the bus. First comes a start condition. Then come nine clock pulses with the data line released, so that any slave still shifting out a byte reaches its acknowledge slot and lets go of the line. A second start condition follows, closed at once by a stop condition. The sequencer then waits out a bus-free interval and pulses done.

Both lines are open-drain. The block only produces pull-low enables for the clock and data lines and never drives either line high. It reads the data line back so that it does not issue a start while a slave still holds data low. Every phase length is a parameter counted in system-clock cycles. One shared down-counter times all the phases. A trigger that arrives while the pattern is running has no effect.

Top module: `bus_recover_seq`

## Requirements
- R1: After reset, both pull-low enables and done are 0.
- R2: On a trigger while idle, the clock line is first left released. The data enable rises only after the data readback has been high for T_SU_STA consecutive cycles. A readback low restarts that wait, and the same rule applies to the second start.
- R3: The first start holds data low with the clock released for T_HD_STA cycles. The clock is then pulled low while data stays low for T_HD_DAT cycles.
- R4: Exactly nine clock pulses follow with data released. Each pulse is T_LOW cycles of clock pulled low, then T_HIGH cycles of clock released.
- R5: After the ninth pulse, the clock is pulled low for T_LOW cycles and then released with data released for T_SU_STA cycles. Data is then pulled low for T_HD_STA+T_SU_STO cycles with the clock released, and then released (the stop).
- R6: After the stop, both enables stay 0 for T_BUF cycles. Done is then 1 for exactly one cycle, with both enables 0.
- R7: The clock enable never changes in the same cycle as the data enable.
- R8: A trigger while the pattern is running is ignored. The pattern in progress is unchanged, done pulses once, and no second pattern follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Starts a recovery pattern when idle |
| sda_in_i | input | 1 | Readback of the data line level |
| scl_low_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls the data line low, 0 releases it |
| done_o | output | 1 | One-cycle pulse once the bus has been free for T_BUF |

## Verification
The bench sets every phase length to a small, distinct value: clock low 6, clock high 4, start setup 3, start hold 5, data hold 2, stop setup 4 and bus free 7. A wrong or swapped timing parameter therefore shows up as a segment of the wrong length. It also keeps a full pattern near 130 cycles, which leaves room for a run with a slave holding data low at the trigger and a run with a stray trigger mid-pattern. The pulse count is kept at nine, so the bench can count every pulse and spot an off-by-one in the pulse count.

// File: rtl/bus_recover_pkg.sv
package bus_recover_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SU1,     // clock released, data released, waiting before first start
    PH_HD1,     // first start: data low, clock released
    PH_EXIT,    // clock low, data still low
    PH_LOW,     // dummy pulse low half
    PH_HIGH,    // dummy pulse high half
    PH_SU2,     // setup before second start
    PH_HD2,     // second start held
    PH_SUSTO,   // data still low before the stop edge
    PH_FREE     // bus free before done
  } phase_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic scl_pull(phase_t p);
    return (p == PH_EXIT) || (p == PH_LOW);
  endfunction

  function automatic logic sda_pull(phase_t p);
    return (p == PH_HD1) || (p == PH_EXIT) || (p == PH_HD2) || (p == PH_SUSTO);
  endfunction

  function automatic logic needs_free_sda(phase_t p);
    return (p == PH_SU1) || (p == PH_SU2);
  endfunction

endpackage

// File: rtl/rcv_timer.sv
module rcv_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] value_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= value_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rcv_pulse_ctr.sv
module rcv_pulse_ctr #(
  parameter int unsigned N_PULSES = 9,
  localparam int unsigned PW = $clog2(N_PULSES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  output logic          all_o,
  output logic [PW-1:0] count_o
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (step_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign all_o   = (cnt_q == PW'(N_PULSES));
  assign count_o = cnt_q;
endmodule

// File: rtl/rcv_line_drive.sv
module rcv_line_drive
  import bus_recover_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase_i,
  input  logic   finish_i,
  output logic   scl_low_o,
  output logic   sda_low_o,
  output logic   done_o
);
  logic fin_q;

  // Every pin is a register: no decode glitch reaches the bus and all
  // outputs share the same one-cycle lag behind the phase register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_low_o <= 1'b0;
      sda_low_o <= 1'b0;
      fin_q     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      scl_low_o <= scl_pull(phase_i);
      sda_low_o <= sda_pull(phase_i);
      fin_q     <= finish_i;
      done_o    <= fin_q;
    end
  end
endmodule

// File: rtl/bus_recover_seq.sv
module bus_recover_seq
  import bus_recover_pkg::*;
#(
  parameter int unsigned T_LOW    = 130,
  parameter int unsigned T_HIGH   = 70,
  parameter int unsigned T_SU_STA = 60,
  parameter int unsigned T_HD_STA = 60,
  parameter int unsigned T_HD_DAT = 5,
  parameter int unsigned T_SU_STO = 60,
  parameter int unsigned T_BUF    = 130,
  parameter int unsigned N_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  input  logic sda_in_i,
  output logic scl_low_o,
  output logic sda_low_o,
  output logic done_o
);
  localparam int unsigned MAX_T = max2(max2(max2(T_LOW, T_HIGH), max2(T_SU_STA, T_HD_STA)),
                                       max2(max2(T_HD_DAT, T_SU_STO), T_BUF));
  localparam int unsigned CW = $clog2(MAX_T + 1);
  localparam int unsigned PW = $clog2(N_PULSES + 1);

  // Remaining-cycles value loaded when a phase is entered.
  function automatic logic [CW-1:0] span_m1(phase_t p);
    int unsigned d;
    case (p)
      PH_SU1, PH_SU2: d = T_SU_STA;
      PH_HD1, PH_HD2: d = T_HD_STA;
      PH_EXIT:        d = T_HD_DAT;
      PH_LOW:         d = T_LOW;
      PH_HIGH:        d = T_HIGH;
      PH_SUSTO:       d = T_SU_STO;
      PH_FREE:        d = T_BUF;
      default:        d = 1;
    endcase
    return CW'(d - 1);
  endfunction

  phase_t          phase_q, phase_d;
  logic            tmr_load, tmr_zero;
  logic [CW-1:0]   tmr_val;
  logic            pulse_clear, pulse_step, pulses_all;
  logic [PW-1:0]   pulse_count;
  logic            finish;
  logic            busy;
  logic            setup_blocked;

  assign busy          = (phase_q != PH_IDLE);
  assign setup_blocked = needs_free_sda(phase_q) && !sda_in_i;

  always_comb begin
    phase_d     = phase_q;
    pulse_clear = 1'b0;
    pulse_step  = 1'b0;
    finish      = 1'b0;
    case (phase_q)
      PH_IDLE:  if (kick_i) begin
                  phase_d     = PH_SU1;
                  pulse_clear = 1'b1;
                end
      PH_SU1:   if (!setup_blocked && tmr_zero) phase_d = PH_HD1;
      PH_HD1:   if (tmr_zero) phase_d = PH_EXIT;
      PH_EXIT:  if (tmr_zero) phase_d = PH_LOW;
      PH_LOW:   if (tmr_zero) phase_d = pulses_all ? PH_SU2 : PH_HIGH;
      PH_HIGH:  if (tmr_zero) begin
                  phase_d    = PH_LOW;
                  pulse_step = 1'b1;
                end
      PH_SU2:   if (!setup_blocked && tmr_zero) phase_d = PH_HD2;
      PH_HD2:   if (tmr_zero) phase_d = PH_SUSTO;
      PH_SUSTO: if (tmr_zero) phase_d = PH_FREE;
      PH_FREE:  if (tmr_zero) begin
                  phase_d = PH_IDLE;
                  finish  = 1'b1;
                end
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (phase_d != phase_q) || setup_blocked;
    tmr_val  = span_m1(phase_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  rcv_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (tmr_load),
    .value_i (tmr_val),
    .zero_o  (tmr_zero)
  );

  rcv_pulse_ctr #(.N_PULSES(N_PULSES)) u_pulses (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (pulse_clear),
    .step_i  (pulse_step),
    .all_o   (pulses_all),
    .count_o (pulse_count)
  );

  rcv_line_drive u_drive (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_i   (phase_q),
    .finish_i  (finish),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o),
    .done_o    (done_o)
  );
endmodule

// File: rtl/bus_recover_chk.sv
module bus_recover_chk #(
  parameter int unsigned N_PULSES = 9,
  localparam int unsigned PW = $clog2(N_PULSES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_in_i,
  input logic          scl_low_o,
  input logic          sda_low_o,
  input logic          done_o,
  input logic [PW-1:0] pulse_count
);
  AST_START_NEEDS_FREE_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low_o) |-> ($past(sda_in_i) && !scl_low_o)); // R2

  AST_PULSES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_count <= PW'(N_PULSES)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scl_low_o && !sda_low_o)); // R6

  AST_SCL_MOVES_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_low_o) |-> $stable(sda_low_o)); // R7
endmodule

bind bus_recover_seq bus_recover_chk #(.N_PULSES(N_PULSES)) u_chk (.*);

// File: tb/sim_bus_recover_seq.sv
module sim_bus_recover_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P_LOW = 6, P_HIGH = 4, P_SU_STA = 3, P_HD_STA = 5;
  localparam int P_HD_DAT = 2, P_SU_STO = 4, P_BUF = 7, P_N = 9;

  typedef struct { logic scl; logic sda; int len; } seg_t;

  logic clk = 1'b0, rst_n = 1'b0, kick = 1'b0, slave_hold = 1'b0;
  logic sda_in, scl_low, sda_low, done;
  seg_t exp_q[$];
  int n_cmp = 0, n_bad = 0, done_seen = 0, cycles = 0;
  logic [1:0] prev = 2'b00;
  logic tracking = 1'b0;
  int run = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_in = ~(sda_low | slave_hold);

  bus_recover_seq #(.T_LOW(P_LOW), .T_HIGH(P_HIGH), .T_SU_STA(P_SU_STA), .T_HD_STA(P_HD_STA),
                    .T_HD_DAT(P_HD_DAT), .T_SU_STO(P_SU_STO), .T_BUF(P_BUF), .N_PULSES(P_N)) u0 (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .sda_in_i(sda_in),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .done_o(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Scoreboard monitor: run-length codes the pull pair and pops expectations.
  task automatic pop_cmp(input logic [1:0] pr, input int len);
    seg_t e;
    if (exp_q.size() == 0) begin
      check(0, "R8 unexpected segment", {pr, 16'(len)}, 0);
      return;
    end
    e = exp_q.pop_front();
    check(pr == {e.scl, e.sda}, "R3/R4/R5 segment pull pair", pr, {e.scl, e.sda});
    check(len == e.len, "R3/R4/R5/R6 segment length", len, e.len);
  endtask

  always @(negedge clk) begin
    logic [1:0] pr;
    if (rst_n) begin
      pr = {scl_low, sda_low};
      if (pr[1] != prev[1] && pr[0] != prev[0])
        check(0, "R7 both enables changed together", pr, prev);
      if (tracking) begin
        if (done) begin
          pop_cmp(prev, run);
          tracking = 1'b0;
        end else if (pr != prev) begin
          pop_cmp(prev, run);
          run = 1;
        end else run++;
      end else if (prev == 2'b00 && pr == 2'b01) begin
        tracking = 1'b1;
        run = 1;
      end
      if (done) done_seen++;
      prev = pr;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      check(0, "watchdog expired", cycles, 50000);
      finish_run();
    end
  end

  task automatic push(input logic s, input logic d, input int len);
    seg_t e;
    e.scl = s; e.sda = d; e.len = len;
    exp_q.push_back(e);
  endtask

  // Driver: queue the pattern the requirements predict, then stimulate.
  task automatic run_seq(input int hold, input bit mid_kick);
    int d0, cnt;
    push(0, 1, P_HD_STA);                       // R3 first start
    push(1, 1, P_HD_DAT);                       // R3 clock drops, data held
    for (int i = 0; i < P_N; i++) begin
      push(1, 0, P_LOW);                        // R4
      push(0, 0, P_HIGH);                       // R4
    end
    push(1, 0, P_LOW);                          // R5
    push(0, 0, P_SU_STA);                       // R5
    push(0, 1, P_HD_STA + P_SU_STO);            // R5 second start then stop
    push(0, 0, P_BUF);                          // R6 bus free before done
    d0 = done_seen;
    @(negedge clk);
    if (hold > 0) slave_hold = 1'b1;
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check(sda_low == 1'b0, "R2 no start while data held low", sda_low, 0);
      slave_hold = 1'b0;
      cnt = 0;
      forever begin
        @(negedge clk);
        if (sda_low) break;
        cnt++;
      end
      check(cnt == P_SU_STA, "R2 setup after data freed", cnt, P_SU_STA);
    end
    if (mid_kick) begin
      repeat (40) @(negedge clk);
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
    end
    while (done_seen == d0) @(negedge clk);
    repeat (P_BUF + 30) @(negedge clk);
    check(done_seen == d0 + 1, "R6/R8 one done per pattern", done_seen - d0, 1);
    check(exp_q.size() == 0, "R8 all segments seen, no extra", exp_q.size(), 0);
    check({scl_low, sda_low} == 2'b00, "R8 bus left released", {scl_low, sda_low}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_low == 1'b0, "R1 clock enable after reset", scl_low, 0);
    check(sda_low == 1'b0, "R1 data enable after reset", sda_low, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_seq(0, 1'b0);
    run_seq(0, 1'b1);
    run_seq(20, 1'b0);
    run_seq(0, 1'b0);
    finish_run();
  end
endmodule